// File: doc/BRIEF.md
# Motion Threshold Interrupt Controller

This block watches a stream of signed three-axis acceleration samples and raises two latched interrupt sources. It has two detectors. A level detector fires on any sample whose axes cross a threshold. A pulse detector fires when the crossing lasts only a short, programmed number of samples and then ends. Each detector has its own threshold and polarity, and both share a per-axis disable mask. A two-bit routing field selects which detector feeds which source.

Each source holds a flag and a record of the axes that caused it. Both stay set until software writes a per-source clear strobe. Two interrupt pins show the two flags, and a swap bit can exchange which pin shows which flag. The block sits between the filtered sample path and the register bank. Configuration arrives as plain inputs, and samples arrive with a one-cycle valid strobe.

Top module: `mtic_top`

## Requirements
- R1: Samples are packed with X in bits 7:0, Y in bits 15:8 and Z in bits 23:16, each an 8-bit two's-complement value. With level polarity 0 and the threshold option 0, an axis meets the level condition when its magnitude (with |-128| = 128) is at least the unsigned level threshold. The level detector fires when any enabled axis meets the condition.
- R2: With a polarity bit at 1, an axis meets the condition when its magnitude is below the threshold. The detector fires only when every enabled axis meets it, and never fires when no axis is enabled. This applies to the level and pulse detectors, each through its own polarity bit.
- R3: With the threshold option at 1, the level detector compares each sample against the threshold as signed values (sample >= threshold, or sample < threshold under negative polarity). The pulse detector always compares magnitudes.
- R4: Mask bit 0 disables X, bit 1 disables Y and bit 2 disables Z. A disabled axis never triggers and never appears in the axis flags.
- R5: The pulse detector counts consecutive valid samples that meet its condition. On the first valid sample that does not meet it, the detector fires if the run lasted from 1 to the programmed duration samples. Longer runs do not fire. A duration of 0 disables the pulse detector. The reported axes are those that met the condition during the run.
- R6: Routing 00 sends level to source 1 and pulse to source 2. Routing 01 sends pulse to source 1 and level to source 2. Routing 10 sends pulse to both sources. Routing 11 sends nothing.
- R7: A source flag, once set, stays set. Its axis flags accumulate over later detections, and the flag is high exactly when at least one axis flag is set.
- R8: A clear strobe for a source empties its flag and axis flags on the next edge, whether or not a sample is valid. If a detection for that source arrives in the same cycle, the flag stays set and the axis flags hold only the new detection's axes.
- R9: With swap at 0, pin 1 shows source flag 1 and pin 2 shows source flag 2. With swap at 1, the pins are exchanged.
- R10: On cycles with the valid strobe low, no detection happens and the pulse run count is unchanged. Only clears take effect.
- R11: A synchronous active-high reset empties all flags, axis flags, pins and the pulse run count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_valid | input | 1 | One-cycle strobe marking a new sample |
| sample_bus | input | 24 | Packed X/Y/Z signed samples |
| route_mode | input | 2 | Detector-to-source routing |
| axis_off | input | 3 | Per-axis disable mask |
| lvl_neg | input | 1 | Level polarity (0: above/OR, 1: below/AND) |
| pls_neg | input | 1 | Pulse polarity (0: above/OR, 1: below/AND) |
| thr_signed | input | 1 | Level threshold compared as signed value |
| lvl_thresh | input | 8 | Level threshold |
| pls_thresh | input | 8 | Pulse threshold |
| pls_width | input | 8 | Longest pulse run in samples; 0 disables |
| pin_swap | input | 1 | Exchange pin-to-flag mapping |
| clr_src1 | input | 1 | Clear strobe for source 1 |
| clr_src2 | input | 1 | Clear strobe for source 2 |
| irq_pin1 | output | 1 | Interrupt pin 1 |
| irq_pin2 | output | 1 | Interrupt pin 2 |
| src_flag1 | output | 1 | Source 1 latched flag |
| src_flag2 | output | 1 | Source 2 latched flag |
| src1_axes | output | 3 | Source 1 axis flags (bit 0 = X) |
| src2_axes | output | 3 | Source 2 axis flags (bit 0 = X) |

## Verification
The properties assume that reset is asserted on the first clock edge and that configuration inputs are stable whenever a sample is valid. They also assume that clear strobes are single-cycle writes and are not held asserted. The stimulus changes configuration only on the falling edge, together with the sample, and it pulses each clear for exactly one cycle. Runs of the pulse detector are allowed to span idle cycles, because the properties about idle cycles assume only that the flags hold, not that the run count is reset.

// File: rtl/mtic_pkg.sv
package mtic_pkg;
   localparam int AXES = 3;

   typedef enum logic [1:0] {
      ROUTE_LVL_PLS  = 2'b00,
      ROUTE_PLS_LVL  = 2'b01,
      ROUTE_PLS_BOTH = 2'b10,
      ROUTE_OFF      = 2'b11
   } route_e;

   typedef struct packed {
      logic            hit;
      logic [AXES-1:0] axes;
   } src_evt_t;
endpackage

// File: rtl/mtic_axis_cmp.sv
// One axis against one threshold: magnitude or signed compare, then polarity.
module mtic_axis_cmp #(
   parameter int W = 8
) (
   input  logic [W-1:0] sample,
   input  logic [W-1:0] thresh,
   input  logic         neg,
   input  logic         thr_signed,
   output logic         meet
);
   logic [W-1:0] mag;
   logic         ge_abs, ge_sgn, ge;

   assign mag    = sample[W-1] ? (~sample + 1'b1) : sample;
   assign ge_abs = (mag >= thresh);
   assign ge_sgn = ($signed(sample) >= $signed(thresh));
   assign ge     = thr_signed ? ge_sgn : ge_abs;
   assign meet   = neg ? ~ge : ge;
endmodule

// File: rtl/mtic_detect.sv
// All axes of one detector: per-axis compare, masking and OR/AND combining.
module mtic_detect
   import mtic_pkg::*;
#(
   parameter int W = 8
) (
   input  logic [AXES*W-1:0] samples,
   input  logic [W-1:0]      thresh,
   input  logic              neg,
   input  logic              thr_signed,
   input  logic [AXES-1:0]   axis_off,
   output logic              cond,
   output logic [AXES-1:0]   hits
);
   logic [AXES-1:0] meet;

   for (genvar g = 0; g < AXES; g++) begin : g_axis
      mtic_axis_cmp #(.W(W)) u_cmp (
         .sample     (samples[g*W +: W]),
         .thresh     (thresh),
         .neg        (neg),
         .thr_signed (thr_signed),
         .meet       (meet[g])
      );
   end

   logic all_ok, any_en;
   assign hits   = meet & ~axis_off;
   assign all_ok = &(meet | axis_off);
   assign any_en = ~&axis_off;
   assign cond   = neg ? (any_en & all_ok) : (|hits);
endmodule

// File: rtl/mtic_pulse_timer.sv
// Run-length timer: fires on the falling end of a short enough run.
module mtic_pulse_timer
   import mtic_pkg::*;
#(
   parameter int DUR_W = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             valid,
   input  logic             cond,
   input  logic [AXES-1:0]  hits,
   input  logic [DUR_W-1:0] width,
   output logic             evt,
   output logic [AXES-1:0]  evt_axes
);
   localparam int CW = DUR_W + 1;
   localparam logic [CW-1:0] RUN_MAX = {1'b1, {DUR_W{1'b0}}};

   logic [CW-1:0]   run_cnt;
   logic [AXES-1:0] run_axes;

   always_ff @(posedge clk) begin
      if (rst) begin
         run_cnt  <= '0;
         run_axes <= '0;
      end else if (valid) begin
         if (cond) begin
            run_cnt  <= (run_cnt == RUN_MAX) ? run_cnt : run_cnt + 1'b1;
            run_axes <= run_axes | hits;
         end else begin
            run_cnt  <= '0;
            run_axes <= '0;
         end
      end
   end

   assign evt      = valid & ~cond & (run_cnt != '0) & (run_cnt <= {1'b0, width});
   assign evt_axes = run_axes;
endmodule

// File: rtl/mtic_src_latch.sv
// One interrupt source: sticky flag plus accumulated axis flags.
module mtic_src_latch
   import mtic_pkg::*;
(
   input  logic            clk,
   input  logic            rst,
   input  src_evt_t        evt,
   input  logic            clr,
   output logic            flag,
   output logic [AXES-1:0] axes
);
   always_ff @(posedge clk) begin
      if (rst) begin
         flag <= 1'b0;
         axes <= '0;
      end else if (evt.hit) begin
         flag <= 1'b1;
         axes <= (clr ? '0 : axes) | evt.axes;
      end else if (clr) begin
         flag <= 1'b0;
         axes <= '0;
      end
   end
endmodule

// File: rtl/mtic_top.sv
module mtic_top
   import mtic_pkg::*;
#(
   parameter int SAMPLE_W = 8,
   parameter int DUR_W    = 8
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     sample_valid,
   input  logic [3*SAMPLE_W-1:0]    sample_bus,
   input  logic [1:0]               route_mode,
   input  logic [2:0]               axis_off,
   input  logic                     lvl_neg,
   input  logic                     pls_neg,
   input  logic                     thr_signed,
   input  logic [SAMPLE_W-1:0]      lvl_thresh,
   input  logic [SAMPLE_W-1:0]      pls_thresh,
   input  logic [DUR_W-1:0]         pls_width,
   input  logic                     pin_swap,
   input  logic                     clr_src1,
   input  logic                     clr_src2,
   output logic                     irq_pin1,
   output logic                     irq_pin2,
   output logic                     src_flag1,
   output logic                     src_flag2,
   output logic [2:0]               src1_axes,
   output logic [2:0]               src2_axes
);
   localparam int N_SRC = 2;

   if (SAMPLE_W < 2) begin : g_bad_sample_w
      $error("mtic_top: SAMPLE_W must be at least 2");
   end
   if (DUR_W < 1) begin : g_bad_dur_w
      $error("mtic_top: DUR_W must be at least 1");
   end

   logic            lvl_cond, pls_cond, pls_evt;
   logic [AXES-1:0] lvl_hits, pls_hits, pls_axes;

   mtic_detect #(.W(SAMPLE_W)) u_lvl (
      .samples (sample_bus), .thresh (lvl_thresh), .neg (lvl_neg),
      .thr_signed (thr_signed), .axis_off (axis_off),
      .cond (lvl_cond), .hits (lvl_hits)
   );

   mtic_detect #(.W(SAMPLE_W)) u_pls (
      .samples (sample_bus), .thresh (pls_thresh), .neg (pls_neg),
      .thr_signed (1'b0), .axis_off (axis_off),
      .cond (pls_cond), .hits (pls_hits)
   );

   mtic_pulse_timer #(.DUR_W(DUR_W)) u_timer (
      .clk (clk), .rst (rst), .valid (sample_valid), .cond (pls_cond),
      .hits (pls_hits), .width (pls_width),
      .evt (pls_evt), .evt_axes (pls_axes)
   );

   src_evt_t lvl_e, pls_e, none_e;
   src_evt_t src_e [N_SRC];

   assign lvl_e  = '{hit: sample_valid & lvl_cond, axes: lvl_hits};
   assign pls_e  = '{hit: pls_evt, axes: pls_axes};
   assign none_e = '{hit: 1'b0, axes: '0};

   always_comb begin
      unique case (route_e'(route_mode))
         ROUTE_LVL_PLS:  begin src_e[0] = lvl_e;  src_e[1] = pls_e;  end
         ROUTE_PLS_LVL:  begin src_e[0] = pls_e;  src_e[1] = lvl_e;  end
         ROUTE_PLS_BOTH: begin src_e[0] = pls_e;  src_e[1] = pls_e;  end
         default:        begin src_e[0] = none_e; src_e[1] = none_e; end
      endcase
   end

   logic [N_SRC-1:0] clr_vec, flag_q;
   logic [AXES-1:0]  axes_q [N_SRC];

   assign clr_vec = {clr_src2, clr_src1};

   for (genvar s = 0; s < N_SRC; s++) begin : g_src
      mtic_src_latch u_latch (
         .clk (clk), .rst (rst), .evt (src_e[s]), .clr (clr_vec[s]),
         .flag (flag_q[s]), .axes (axes_q[s])
      );
   end

   assign src_flag1 = flag_q[0];
   assign src_flag2 = flag_q[1];
   assign src1_axes = axes_q[0];
   assign src2_axes = axes_q[1];
   assign irq_pin1  = pin_swap ? flag_q[1] : flag_q[0];
   assign irq_pin2  = pin_swap ? flag_q[0] : flag_q[1];
endmodule

// File: rtl/mtic_chk.sv
module mtic_chk (
   input logic       clk,
   input logic       rst,
   input logic       sample_valid,
   input logic [1:0] route_mode,
   input logic [7:0] pls_width,
   input logic       clr_src1,
   input logic       clr_src2,
   input logic       irq_pin1,
   input logic       irq_pin2,
   input logic       src_flag1,
   input logic       src_flag2,
   input logic [2:0] src1_axes,
   input logic [2:0] src2_axes
);
   assert_flag_axes_agree_R7: assert property (@(posedge clk) disable iff (rst)
      (src_flag1 == (src1_axes != 3'b000)) && (src_flag2 == (src2_axes != 3'b000)));

   assert_idle_hold1_R10: assert property (@(posedge clk) disable iff (rst)
      (!sample_valid && !clr_src1) |=> ($stable(src_flag1) && $stable(src1_axes)));

   assert_idle_hold2_R10: assert property (@(posedge clk) disable iff (rst)
      (!sample_valid && !clr_src2) |=> ($stable(src_flag2) && $stable(src2_axes)));

   assert_rise_needs_valid_R10: assert property (@(posedge clk) disable iff (rst)
      ($rose(src_flag1) || $rose(src_flag2)) |-> $past(sample_valid));

   assert_idle_clear1_R8: assert property (@(posedge clk) disable iff (rst)
      (clr_src1 && !sample_valid) |=> (!src_flag1 && src1_axes == 3'b000));

   assert_idle_clear2_R8: assert property (@(posedge clk) disable iff (rst)
      (clr_src2 && !sample_valid) |=> (!src_flag2 && src2_axes == 3'b000));

   assert_route_off_R6: assert property (@(posedge clk) disable iff (rst)
      (route_mode == 2'b11 && !clr_src1 && !clr_src2) |=>
         ($stable(src1_axes) && $stable(src2_axes)));

   assert_width_zero_R5: assert property (@(posedge clk) disable iff (rst)
      (route_mode == 2'b10 && pls_width == 8'd0 && !clr_src1 && !clr_src2) |=>
         ($stable(src_flag1) && $stable(src_flag2)));

   assert_pin_count_R9: assert property (@(posedge clk) disable iff (rst)
      $countones({irq_pin1, irq_pin2}) == $countones({src_flag1, src_flag2}));
endmodule

bind mtic_top mtic_chk u_chk (
   .clk (clk), .rst (rst), .sample_valid (sample_valid), .route_mode (route_mode),
   .pls_width (pls_width), .clr_src1 (clr_src1), .clr_src2 (clr_src2),
   .irq_pin1 (irq_pin1), .irq_pin2 (irq_pin2), .src_flag1 (src_flag1),
   .src_flag2 (src_flag2), .src1_axes (src1_axes), .src2_axes (src2_axes)
);

// File: tb/sim_mtic_top.sv
`timescale 1ns/1ps
module sim_mtic_top;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       sample_valid = 1'b0;
   logic [23:0] sample_bus = '0;
   logic [1:0] route_mode = 2'b00;
   logic [2:0] axis_off = 3'b000;
   logic       lvl_neg = 1'b0, pls_neg = 1'b0, thr_signed = 1'b0, pin_swap = 1'b0;
   logic [7:0] lvl_thresh = 8'h28, pls_thresh = 8'h32, pls_width = 8'd2;
   logic       clr_src1 = 1'b0, clr_src2 = 1'b0;
   logic       irq_pin1, irq_pin2, src_flag1, src_flag2;
   logic [2:0] src1_axes, src2_axes;

   int n_chk = 0;
   int n_bad = 0;

   always #4 clk = ~clk;

   mtic_top u0 (.*);

   // {req, mode, mask, lneg, pneg, tsig, swap, clr1, clr2, x, y, z, exp}
   // exp = {pin1, pin2, flag1, flag2, axes1, axes2}
   typedef struct packed {
      logic [3:0] req;
      logic [1:0] mode;
      logic [2:0] mask;
      logic       lneg, pneg, tsig, swap, c1, c2;
      logic [7:0] x, y, z;
      logic [9:0] exp;
   } vec_t;

   localparam int NV = 23;
   localparam vec_t TBL [NV] = '{
      '{4'd1, 2'd0, 3'b000, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 8'h2D,8'h00,8'h00, 10'b1_0_1_0_001_000}, // R1
      '{4'd8, 2'd0, 3'b000, 1'b0,1'b0,1'b0,1'b0,1'b1,1'b0, 8'h00,8'hC4,8'h00, 10'b1_0_1_0_010_000}, // R8
      '{4'd5, 2'd0, 3'b000, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 8'h00,8'h00,8'h00, 10'b1_1_1_1_010_010}, // R5
      '{4'd8, 2'd0, 3'b000, 1'b0,1'b0,1'b0,1'b0,1'b1,1'b1, 8'h00,8'h00,8'h00, 10'b0_0_0_0_000_000}, // R8
      '{4'd6, 2'd1, 3'b000, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 8'h00,8'h00,8'h9C, 10'b0_1_0_1_000_100}, // R6
      '{4'd7, 2'd1, 3'b000, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 8'h00,8'h00,8'h9C, 10'b0_1_0_1_000_100}, // R7
      '{4'd5, 2'd1, 3'b000, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 8'h00,8'h00,8'h9C, 10'b0_1_0_1_000_100}, // R5
      '{4'd5, 2'd1, 3'b000, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 8'h00,8'h00,8'h00, 10'b0_1_0_1_000_100}, // R5 run too long
      '{4'd9, 2'd1, 3'b000, 1'b0,1'b0,1'b0,1'b1,1'b0,1'b0, 8'h46,8'h00,8'h00, 10'b1_0_0_1_000_101}, // R9
      '{4'd9, 2'd1, 3'b000, 1'b0,1'b0,1'b0,1'b1,1'b0,1'b0, 8'h00,8'h00,8'h00, 10'b1_1_1_1_001_101}, // R9
      '{4'd8, 2'd1, 3'b000, 1'b0,1'b0,1'b0,1'b0,1'b1,1'b1, 8'h00,8'h00,8'h00, 10'b0_0_0_0_000_000}, // R8
      '{4'd2, 2'd0, 3'b100, 1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 8'h0A,8'hEC,8'h64, 10'b1_0_1_0_011_000}, // R2
      '{4'd2, 2'd0, 3'b100, 1'b1,1'b0,1'b0,1'b0,1'b1,1'b0, 8'h0A,8'h32,8'h00, 10'b0_0_0_0_000_000}, // R2
      '{4'd3, 2'd0, 3'b000, 1'b0,1'b0,1'b1,1'b0,1'b0,1'b0, 8'h9C,8'hCE,8'h1E, 10'b0_0_0_0_000_000}, // R3
      '{4'd3, 2'd0, 3'b000, 1'b0,1'b0,1'b1,1'b0,1'b0,1'b0, 8'h28,8'h00,8'h00, 10'b1_1_1_1_001_011}, // R3
      '{4'd6, 2'd2, 3'b000, 1'b0,1'b0,1'b0,1'b0,1'b1,1'b1, 8'h3C,8'h00,8'h00, 10'b0_0_0_0_000_000}, // R6
      '{4'd6, 2'd2, 3'b000, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 8'h00,8'h00,8'h00, 10'b1_1_1_1_001_001}, // R6
      '{4'd6, 2'd3, 3'b000, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 8'h3C,8'h00,8'h00, 10'b1_1_1_1_001_001}, // R6
      '{4'd6, 2'd3, 3'b000, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 8'h00,8'h00,8'h00, 10'b1_1_1_1_001_001}, // R6
      '{4'd8, 2'd0, 3'b000, 1'b0,1'b0,1'b0,1'b0,1'b1,1'b1, 8'h00,8'h00,8'h00, 10'b0_0_0_0_000_000}, // R8
      '{4'd2, 2'd0, 3'b000, 1'b0,1'b1,1'b0,1'b0,1'b0,1'b0, 8'h00,8'h00,8'h00, 10'b0_0_0_0_000_000}, // R2
      '{4'd5, 2'd0, 3'b000, 1'b0,1'b1,1'b0,1'b0,1'b0,1'b0, 8'h50,8'h00,8'h00, 10'b1_1_1_1_001_111}, // R5
      '{4'd8, 2'd0, 3'b000, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b1, 8'h00,8'h00,8'h00, 10'b1_0_1_0_001_000}  // R8
   };

   function automatic logic [9:0] observed();
      return {irq_pin1, irq_pin2, src_flag1, src_flag2, src1_axes, src2_axes};
   endfunction

   task automatic check(input string tag, input logic [9:0] expv);
      logic [9:0] act;
      act = observed();
      n_chk++;
      if (act !== expv) begin
         n_bad++;
         $display("FAIL %s actual=%b expected=%b", tag, act, expv);
      end
   endtask

   task automatic drive(input logic v, input logic [1:0] m, input logic [2:0] msk,
                        input logic ln, input logic pn, input logic ts, input logic sw,
                        input logic c1, input logic c2,
                        input logic [7:0] x, input logic [7:0] y, input logic [7:0] z);
      sample_valid = v;  route_mode = m; axis_off = msk;
      lvl_neg = ln; pls_neg = pn; thr_signed = ts; pin_swap = sw;
      clr_src1 = c1; clr_src2 = c2; sample_bus = {z, y, x};
   endtask

   initial begin : watchdog
      #(8 * 200000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin : stim
      repeat (3) @(negedge clk);
      check("R11 reset", 10'b0);
      rst = 1'b0;

      for (int i = 0; i < NV; i++) begin
         drive(1'b1, TBL[i].mode, TBL[i].mask, TBL[i].lneg, TBL[i].pneg, TBL[i].tsig,
               TBL[i].swap, TBL[i].c1, TBL[i].c2, TBL[i].x, TBL[i].y, TBL[i].z);
         @(negedge clk);
         check($sformatf("R%0d vec%0d", TBL[i].req, i), TBL[i].exp);
      end

      // R11: reset mid-run empties everything
      drive(1'b0, 2'd0, 3'b000, 0,0,0,0, 0,0, 8'h00,8'h00,8'h00);
      rst = 1'b1;
      repeat (2) @(negedge clk);
      check("R11 reset after activity", 10'b0);
      rst = 1'b0;

      // R10: invalid sample ignored
      drive(1'b0, 2'd0, 3'b000, 0,0,0,0, 0,0, 8'h64,8'h00,8'h00);
      @(negedge clk);
      check("R10 invalid sample ignored", 10'b0);
      drive(1'b1, 2'd0, 3'b000, 0,0,0,0, 0,0, 8'h64,8'h00,8'h00);
      @(negedge clk);
      check("R1 valid sample detected", 10'b1_0_1_0_001_000);
      // R8: clear on an idle cycle
      drive(1'b0, 2'd0, 3'b000, 0,0,0,0, 1,0, 8'h00,8'h00,8'h00);
      @(negedge clk);
      check("R8 clear without valid", 10'b0);
      // R10: pulse run survives idle cycles, ends on next valid drop
      drive(1'b0, 2'd0, 3'b000, 0,0,0,0, 0,0, 8'h00,8'h00,8'h00);
      @(negedge clk);
      drive(1'b1, 2'd0, 3'b000, 0,0,0,0, 0,0, 8'h00,8'h00,8'h00);
      @(negedge clk);
      check("R10 run held over idle cycles", 10'b0_1_0_1_000_001);
      drive(1'b0, 2'd0, 3'b000, 0,0,0,0, 0,1, 8'h00,8'h00,8'h00);
      @(negedge clk);
      check("R8 clear source 2", 10'b0);

      // R1: |-128| equals 128 and meets an unsigned threshold of 128
      lvl_thresh = 8'h80;
      drive(1'b1, 2'd0, 3'b000, 0,0,0,0, 0,0, 8'h80,8'h00,8'h00);
      @(negedge clk);
      check("R1 magnitude of -128", 10'b1_0_1_0_001_000);
      drive(1'b1, 2'd0, 3'b000, 0,0,0,0, 1,0, 8'h7F,8'h00,8'h00);
      @(negedge clk);
      check("R1 127 below 128", 10'b0);
      // R5: duration 0 disables the pulse detector
      pls_width = 8'd0;
      drive(1'b1, 2'd2, 3'b000, 0,0,0,0, 0,0, 8'h00,8'h00,8'h00);
      @(negedge clk);
      check("R5 duration zero", 10'b0);

      // R2: negative polarity with every axis disabled never fires
      lvl_thresh = 8'h28;
      drive(1'b1, 2'd0, 3'b111, 1,0,0,0, 0,0, 8'h00,8'h00,8'h00);
      @(negedge clk);
      check("R2 no enabled axis", 10'b0);
      // R4: disabled X axis never triggers
      drive(1'b1, 2'd0, 3'b001, 0,0,0,0, 0,0, 8'h7F,8'h00,8'h00);
      @(negedge clk);
      check("R4 masked axis", 10'b0);
      drive(1'b1, 2'd0, 3'b001, 0,0,0,0, 0,0, 8'h7F,8'h7F,8'h00);
      @(negedge clk);
      check("R4 enabled axis only", 10'b1_0_1_0_010_000);

      drive(1'b0, 2'd0, 3'b000, 0,0,0,0, 0,0, 8'h00,8'h00,8'h00);
      @(negedge clk);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule